// File: doc/BRIEF.md
# Priority Pin Crossbar

This block connects a fixed set of internal peripheral signal groups to a bank of 32 I/O pins arranged as four 8-bit ports. No pin is tied to a fixed function. Each enabled group takes the next free pins, counted upward from pin 0. Groups are placed in a fixed priority order. When a group is disabled, every group ranked below it moves down to close the gap. Pins that no group claims become general-purpose port bits, driven from the port latch value and direction inputs.

Only ports 0 to 2 (pins 0 to 23) take part in routing. Port 3 is always general-purpose. A parameter gives the number of ports the package brings out. Groups that do not fit in the routable pins of that package are left unassigned. Pins that are not brought out never drive. The pin map is purely combinational, so a change on any input shows on the outputs in the same cycle.

There is no sequencing, so the block has no states. The map is a running sum, taken in rank order, of the widths of the groups that have been granted.

Top module: `prio_xbar`

## Requirements
- R1: While `xbar_en` is 0, every `pin_oe` bit is 0 and every `fn_in` bit reads 1, whatever `grp_en` holds.
- R2: With `xbar_en` = 1 and group 0 enabled, function signals 0 and 1 appear on pins 0 and 1.
- R3: Groups are ranked 0 to 7 with widths 2, 4, 2, 6, 2, 4, 2, 1. The flattened signal index is the sum of the widths of the lower-ranked groups plus the index within the group. Enabled and granted groups take contiguous pins from pin 0 in rank order, with no gaps and no shared pins. A disabled group leaves no hole.
- R4: Pin `start+k` of a granted group drives `fn_out` and `fn_oe` of that group's signal k.
- R5: Pins not claimed by any group drive `gpio_out[p]` with enable `gpio_oe[p]` (enable forced to 0 while `xbar_en` = 0).
- R6: Pins 24 to 31 always follow `gpio_out` and `gpio_oe`, and are never claimed by a group.
- R7: The routable pin count is min(`PORTS_PINNED`, 3) × 8. A group that would extend past it is not granted and adds nothing to the running sum. Later groups that still fit are packed directly after the last granted group.
- R8: Pins at or above `PORTS_PINNED` × 8 always have `pin_oe` = 0.
- R9: Each `fn_in` bit of a granted signal equals `pin_in` at that signal's pin. Each `fn_in` bit of a signal that is not granted reads 1.
- R10: `port_rd` always equals `pin_in`, independent of routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xbar_en | input | 1 | Global routing enable |
| grp_en | input | 8 | Per-group select, bit g = group of rank g |
| fn_out | input | 23 | Peripheral output values, flattened by group |
| fn_oe | input | 23 | Peripheral output enables, flattened by group |
| fn_in | output | 23 | Pin levels returned to peripherals, 1 when unassigned |
| gpio_out | input | 32 | Port latch output values |
| gpio_oe | input | 32 | Port latch output enables |
| pin_in | input | 32 | Sampled pad levels |
| pin_out | output | 32 | Pad drive values |
| pin_oe | output | 32 | Pad output enables |
| port_rd | output | 32 | Port latch read path |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, after zero register stages. The bench applies each stimulus on the falling clock edge and samples 5 ns later, well before the next rising edge. The bench sweeps all 256 group-enable patterns on a full package and on a one-port package, and compares every pin and return signal against a model that packs groups by arithmetic.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;

    localparam int NGRP = 8;
    // rank order: two-wire bus, SPI, UART, capture/compare, comparators,
    // timers, external interrupts, clock out
    localparam int GRP_W [NGRP] = '{2, 4, 2, 6, 2, 4, 2, 1};

    function automatic int grp_base(input int g);
        int s;
        s = 0;
        for (int i = 0; i < g; i++) s += GRP_W[i];
        return s;
    endfunction

    localparam int NSIG = grp_base(NGRP);

    function automatic int sig_grp(input int s);
        int r;
        r = 0;
        for (int i = 0; i < NGRP; i++)
            if (s >= grp_base(i)) r = i;
        return r;
    endfunction

endpackage

// File: rtl/prio_xbar_alloc.sv
module prio_xbar_alloc
    import prio_xbar_pkg::*;
#(
    parameter int ROUTE_PINS = 24,
    parameter int PIX        = 5
) (
    input  logic                      xbar_en,
    input  logic [NGRP-1:0]           grp_en,
    output logic [NGRP-1:0]           granted,
    output logic [NGRP-1:0][PIX-1:0]  start
);

    // running sum over granted groups only
    always_comb begin
        int acc;
        acc = 0;
        for (int g = 0; g < NGRP; g++) begin
            start[g]   = PIX'(acc);
            granted[g] = xbar_en && grp_en[g] && (acc + GRP_W[g] <= ROUTE_PINS);
            if (granted[g]) acc += GRP_W[g];
        end
    end

    always_comb begin
        for (int g = 0; g < NGRP; g++)
            for (int h = g + 1; h < NGRP; h++)
                if (granted[g] && granted[h])
                    AST_NO_OVERLAP: assert (int'(start[h]) >= int'(start[g]) + GRP_W[g])
                        else $error("groups %0d and %0d overlap", g, h); // R3
    end

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            if (granted[g] && !seen)
                AST_PACK_FROM_ZERO: assert (start[g] == '0)
                    else $error("first granted group not at pin 0"); // R3
            if (granted[g]) seen = 1'b1;
        end
    end

endmodule

// File: rtl/prio_xbar_pin_mux.sv
module prio_xbar_pin_mux
    import prio_xbar_pkg::*;
#(
    parameter int NPIN        = 32,
    parameter int PINNED_PINS = 32,
    parameter int PIX         = 5
) (
    input  logic                      xbar_en,
    input  logic [NSIG-1:0]           sig_ok,
    input  logic [NSIG-1:0][PIX-1:0]  sig_pin,
    input  logic [NSIG-1:0]           fn_out,
    input  logic [NSIG-1:0]           fn_oe,
    input  logic [NPIN-1:0]           gpio_out,
    input  logic [NPIN-1:0]           gpio_oe,
    output logic [NPIN-1:0]           pin_out,
    output logic [NPIN-1:0]           pin_oe
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam logic PIN_LIVE = (p < PINNED_PINS);
        logic [NSIG-1:0] claim;

        always_comb
            for (int s = 0; s < NSIG; s++)
                claim[s] = sig_ok[s] && (sig_pin[s] == PIX'(p));

        always_comb begin
            if (|claim) begin
                pin_out[p] = |(claim & fn_out);
                pin_oe[p]  = |(claim & fn_oe);
            end else begin
                pin_out[p] = gpio_out[p];
                pin_oe[p]  = xbar_en & gpio_oe[p];
            end
            if (!PIN_LIVE) pin_oe[p] = 1'b0;
        end

        always_comb
            AST_ONE_OWNER: assert ($onehot0(claim))
                else $error("pin %0d claimed twice", p); // R3
    end

endmodule

// File: rtl/prio_xbar_in_route.sv
module prio_xbar_in_route
    import prio_xbar_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int PIX  = 5
) (
    input  logic [NSIG-1:0]           sig_ok,
    input  logic [NSIG-1:0][PIX-1:0]  sig_pin,
    input  logic [NPIN-1:0]           pin_in,
    output logic [NSIG-1:0]           fn_in
);

    always_comb
        for (int s = 0; s < NSIG; s++)
            fn_in[s] = sig_ok[s] ? pin_in[sig_pin[s]] : 1'b1;

endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
    import prio_xbar_pkg::*;
#(
    parameter int PORT_W       = 8,
    parameter int NPORT        = 4,
    parameter int ROUTE_PORTS  = 3,
    parameter int PORTS_PINNED = 4
) (
    input  logic                      xbar_en,
    input  logic [NGRP-1:0]           grp_en,
    input  logic [NSIG-1:0]           fn_out,
    input  logic [NSIG-1:0]           fn_oe,
    output logic [NSIG-1:0]           fn_in,
    input  logic [NPORT*PORT_W-1:0]   gpio_out,
    input  logic [NPORT*PORT_W-1:0]   gpio_oe,
    input  logic [NPORT*PORT_W-1:0]   pin_in,
    output logic [NPORT*PORT_W-1:0]   pin_out,
    output logic [NPORT*PORT_W-1:0]   pin_oe,
    output logic [NPORT*PORT_W-1:0]   port_rd
);

    localparam int NPIN        = NPORT * PORT_W;
    localparam int PIX         = $clog2(NPIN);
    localparam int ROUTE_SPAN  = ROUTE_PORTS * PORT_W;
    localparam int ROUTE_PINS  = ((PORTS_PINNED < ROUTE_PORTS) ? PORTS_PINNED : ROUTE_PORTS) * PORT_W;
    localparam int PINNED_PINS = PORTS_PINNED * PORT_W;
    localparam logic [NPIN-1:0] PIN_MASK = NPIN'((64'(1) << PINNED_PINS) - 64'(1));

    logic [NGRP-1:0]           granted;
    logic [NGRP-1:0][PIX-1:0]  start;
    logic [NSIG-1:0]           sig_ok;
    logic [NSIG-1:0][PIX-1:0]  sig_pin;

    prio_xbar_alloc #(.ROUTE_PINS(ROUTE_PINS), .PIX(PIX)) u_alloc (
        .xbar_en (xbar_en),
        .grp_en  (grp_en),
        .granted (granted),
        .start   (start)
    );

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        localparam int G = sig_grp(s);
        localparam int K = s - grp_base(G);
        assign sig_ok[s]  = granted[G];
        assign sig_pin[s] = start[G] + PIX'(K);
    end

    prio_xbar_pin_mux #(.NPIN(NPIN), .PINNED_PINS(PINNED_PINS), .PIX(PIX)) u_mux (
        .xbar_en  (xbar_en),
        .sig_ok   (sig_ok),
        .sig_pin  (sig_pin),
        .fn_out   (fn_out),
        .fn_oe    (fn_oe),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    prio_xbar_in_route #(.NPIN(NPIN), .PIX(PIX)) u_in (
        .sig_ok  (sig_ok),
        .sig_pin (sig_pin),
        .pin_in  (pin_in),
        .fn_in   (fn_in)
    );

    assign port_rd = pin_in;

    always_comb begin
        AST_IDLE_NO_DRIVE: assert (xbar_en || pin_oe == '0)
            else $error("pin driven while crossbar off"); // R1
        AST_IDLE_INPUTS_HIGH: assert (xbar_en || &fn_in)
            else $error("function input low while crossbar off"); // R1
        AST_UNPINNED_QUIET: assert ((pin_oe & ~PIN_MASK) == '0)
            else $error("absent pin driven"); // R8
    end

    if (NPORT > ROUTE_PORTS) begin : g_fixed_port
        always_comb
            AST_PORT3_GPIO: assert (pin_out[NPIN-1:ROUTE_SPAN] == gpio_out[NPIN-1:ROUTE_SPAN])
                else $error("non-routed port taken by a function"); // R6
    end

endmodule

// File: tb/prio_xbar_test.sv
module prio_xbar_test;
    import prio_xbar_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            xbar_en;
    logic [7:0]      grp_en;
    logic [22:0]     fn_out, fn_oe;
    logic [31:0]     gpio_out, gpio_oe, pin_in;
    logic [22:0]     fn_in, fn_in_s;
    logic [31:0]     pin_out, pin_oe, port_rd;
    logic [31:0]     pin_out_s, pin_oe_s, port_rd_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    prio_xbar uut (
        .xbar_en(xbar_en), .grp_en(grp_en), .fn_out(fn_out), .fn_oe(fn_oe),
        .fn_in(fn_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd)
    );

    prio_xbar #(.PORTS_PINNED(1)) uut_small (
        .xbar_en(xbar_en), .grp_en(grp_en), .fn_out(fn_out), .fn_oe(fn_oe),
        .fn_in(fn_in_s), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_in(pin_in),
        .pin_out(pin_out_s), .pin_oe(pin_oe_s), .port_rd(port_rd_s)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // packs groups by arithmetic from the requirement text
    task automatic model(input int route, input int pinned,
                         output logic [31:0] eo, output logic [31:0] eoe,
                         output logic [31:0] efi);
        int w [8] = '{2, 4, 2, 6, 2, 4, 2, 1};
        int base = 0;
        int acc  = 0;
        eo  = gpio_out;
        eoe = xbar_en ? gpio_oe : 32'h0;
        efi = 32'h007F_FFFF;
        for (int g = 0; g < 8; g++) begin
            if (xbar_en && grp_en[g] && (acc + w[g] <= route)) begin
                for (int k = 0; k < w[g]; k++) begin
                    eo[acc+k]   = fn_out[base+k];
                    eoe[acc+k]  = fn_oe[base+k];
                    efi[base+k] = pin_in[acc+k];
                end
                acc += w[g];
            end
            base += w[g];
        end
        for (int p = pinned; p < 32; p++) eoe[p] = 1'b0;
    endtask

    task automatic apply(input logic xe, input logic [7:0] en, input int seed);
        @(negedge clk);
        xbar_en  = xe;
        grp_en   = en;
        fn_out   = 23'(seed * 40503) ^ 23'h5A5A5;
        fn_oe    = ~23'(seed * 7919) ^ 23'h13579;
        gpio_out = 32'(seed) * 32'h9E37_79B1;
        gpio_oe  = ~(32'(seed) * 32'h85EB_CA6B);
        pin_in   = (32'(seed) * 32'hC2B2_AE35) ^ 32'hC3C3_3C3C;
        #5;
    endtask

    initial begin
        logic [31:0] eo, eoe, efi;
        xbar_en = 1'b0; grp_en = '0; fn_out = '0; fn_oe = '0;
        gpio_out = '0; gpio_oe = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset/idle state: R1
        @(negedge clk); #5;
        check("R1 idle oe", pin_oe, 32'h0);
        check("R1 idle fn_in", 32'(fn_in), 32'h007F_FFFF);

        // R1 with every group selected but crossbar off
        apply(1'b0, 8'hFF, 77);
        check("R1 off oe", pin_oe, 32'h0);
        check("R1 off fn_in", 32'(fn_in), 32'h007F_FFFF);
        check("R5 off out", pin_out, gpio_out);

        // R2: top-ranked group alone
        apply(1'b1, 8'h01, 5);
        check("R2 pins 0-1", 32'(pin_out[1:0]), 32'(fn_out[1:0]));
        check("R2 oe 0-1", 32'(pin_oe[1:0]), 32'(fn_oe[1:0]));

        // R3: rank 0 off, SPI shifts to pin 0, UART follows at 4
        apply(1'b1, 8'h06, 9);
        check("R3 shift out", 32'(pin_out[5:0]), 32'({fn_out[7:6], fn_out[5:2]}));
        check("R3 gap gpio", pin_out[31:6], gpio_out[31:6]);

        // R6: port 3 with everything enabled
        apply(1'b1, 8'hFF, 31);
        check("R6 port3 out", 32'(pin_out[31:24]), 32'(gpio_out[31:24]));
        check("R6 port3 oe", 32'(pin_oe[31:24]), 32'(gpio_oe[31:24]));

        // sweep all enable patterns, both packages
        for (int c = 0; c < 256; c++) begin
            apply(1'b1, 8'(c), c + 1000);
            model(24, 32, eo, eoe, efi);
            check("R4 pin_out", pin_out, eo);
            check("R5 pin_oe", pin_oe, eoe);
            check("R9 fn_in", 32'(fn_in), efi);
            check("R10 port_rd", port_rd, pin_in);
            model(8, 8, eo, eoe, efi);
            check("R7 small out", pin_out_s, eo);
            check("R8 small oe", pin_oe_s, eoe);
            check("R7 small fn_in", 32'(fn_in_s), efi);
        end

        // sweep with crossbar off on the small package
        for (int c = 0; c < 256; c += 17) begin
            apply(1'b0, 8'(c), c + 3);
            check("R1 small off oe", pin_oe_s, 32'h0);
            check("R10 small rd", port_rd_s, pin_in);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule